// File: doc/BRIEF.md
# Keypad-Programmed Seconds Timer

This block turns decoded key events into a timed countdown. A matrix keypad encoder upstream delivers a 4-bit key code with a one-cycle valid strobe. Decimal keys build a two-digit period of 0 to 99 seconds, which the block converts to binary. The start key loads that value into a down counter that steps on an external 1 Hz tick. When the count runs out, an alarm phase lasting a fixed number of ticks gates an external tone waveform onto the buzzer output. A clear key returns everything to rest.

The ready LED is steady on when idle, follows an external 2 Hz strobe while the countdown runs, and is dark during the alarm. The seconds output shows the remaining count while timing and the entered value at all other times.

Top module: `kpad_timer`

## Requirements
- R1: After reset, timing_o and alarm_o are 0, led_o is 1, tone_o is 0 and secs_o is 0.
- R2: A key code 0 to 9 becomes the new units digit, and the old units digit moves into the tens place. In idle, secs_o shows tens*10+units from the cycle after the key.
- R3: Key codes 0xA, 0xB, 0xD and 0xE change neither the digits nor any output.
- R4: The entry 9,9 is shown on secs_o as binary 1100011 (99), the largest value.
- R5: Start key code 0xF, when not timing and with a nonzero entry, sets timing_o in the next cycle and loads secs_o with the entered value.
- R6: Start has no effect while the entered value is zero.
- R7: Start has no effect while timing is in progress, and the remaining count is kept.
- R8: Each tick while timing lowers secs_o by one. The tick that would bring it to zero ends timing and raises alarm_o in the next cycle. timing_o and alarm_o are never both high.
- R9: alarm_o stays high for exactly 10 ticks, then the block returns to idle.
- R10: led_o is 1 in idle, equals blink_i while timing, and is 0 during the alarm.
- R11: tone_o equals tone_wave_i during the alarm and is 0 otherwise.
- R12: Clear key code 0xC stops timing or the alarm and sets both digits to zero in the next cycle. Clear wins over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | One-cycle strobe marking a key event |
| key_code_i | input | 4 | Decoded key code |
| tick_i | input | 1 | One-cycle pulse at 1 Hz, the time base |
| blink_i | input | 1 | 2 Hz strobe for the busy LED |
| tone_wave_i | input | 1 | About 1.5 kHz square wave for the buzzer |
| led_o | output | 1 | Ready / busy LED |
| tone_o | output | 1 | Buzzer drive |
| timing_o | output | 1 | Countdown in progress |
| alarm_o | output | 1 | Alarm phase in progress |
| secs_o | output | 7 | Remaining seconds while timing, else the entered value |

## Verification
Digit entry is driven with two-digit, three-digit and maximum sequences, mixed with the unused codes A, B, D and E. This tells a correct shift and BCD-to-binary weighting from swapped or dropped digits. Countdowns of 3 and 1 seconds show whether the final tick leads straight into the alarm. An alarm that is counted through to its end checks the fixed tick length. Start is pressed on a zero entry and again mid-count, and clear is pressed mid-count and mid-alarm, to separate the priority between the controls. The blink and tone inputs are toggled in each phase to confirm which phase passes them through.

// File: rtl/kt_pkg.sv
package kt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ALARM = 2'd2
  } kt_state_e;

  localparam logic [3:0] KEY_START = 4'hF;
  localparam logic [3:0] KEY_CLEAR = 4'hC;

  function automatic logic is_digit(input logic [3:0] code);
    return code <= 4'd9;
  endfunction
endpackage

// File: rtl/kt_entry.sv
module kt_entry #(
  parameter int NUM_DIG = 2,
  parameter int VAL_W   = $clog2(10**NUM_DIG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             digit_i,
  input  logic [3:0]       code_i,
  input  logic             clear_i,
  output logic [VAL_W-1:0] value_o
);
  // dig_q[0] is units, dig_q[NUM_DIG-1] most significant
  logic [3:0] dig_q [NUM_DIG];

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dig_q[g] <= '0;
      else if (clear_i) dig_q[g] <= '0;
      else if (digit_i) begin
        if (g == 0) dig_q[g] <= code_i;
        else        dig_q[g] <= dig_q[g-1];
      end
    end
  end

  always_comb begin
    logic [VAL_W-1:0] acc;
    acc = '0;
    for (int i = NUM_DIG - 1; i >= 0; i--) begin
      acc = acc * VAL_W'(10) + VAL_W'(dig_q[i]);
    end
    value_o = acc;
  end
endmodule

// File: rtl/kt_ctrl.sv
module kt_ctrl
  import kt_pkg::*;
#(
  parameter int VAL_W       = 7,
  parameter int ALARM_TICKS = 10,
  localparam int AL_W       = $clog2(ALARM_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [VAL_W-1:0] value_i,
  output kt_state_e        state_o,
  output logic [VAL_W-1:0] count_o
);
  kt_state_e        state_q;
  logic [VAL_W-1:0] cnt_q;
  logic [AL_W-1:0]  acnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      acnt_q  <= '0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      acnt_q  <= '0;
    end else if (start_i && state_q != ST_RUN && value_i != '0) begin
      state_q <= ST_RUN;
      cnt_q   <= value_i;
      acnt_q  <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_RUN: begin
          if (cnt_q == VAL_W'(1)) begin
            state_q <= ST_ALARM;
            cnt_q   <= '0;
            acnt_q  <= AL_W'(ALARM_TICKS);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ALARM: begin
          if (acnt_q == AL_W'(1)) state_q <= ST_IDLE;
          acnt_q <= acnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/kt_outmux.sv
module kt_outmux
  import kt_pkg::*;
#(
  parameter int VAL_W = 7
) (
  input  kt_state_e        state_i,
  input  logic [VAL_W-1:0] count_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic             blink_i,
  input  logic             tone_wave_i,
  output logic             led_o,
  output logic             tone_o,
  output logic             timing_o,
  output logic             alarm_o,
  output logic [VAL_W-1:0] secs_o
);
  always_comb begin
    timing_o = (state_i == ST_RUN);
    alarm_o  = (state_i == ST_ALARM);
    led_o    = timing_o ? blink_i : (state_i == ST_IDLE);
    tone_o   = alarm_o & tone_wave_i;
    secs_o   = timing_o ? count_i : value_i;
  end
endmodule

// File: rtl/kpad_timer.sv
module kpad_timer
  import kt_pkg::*;
#(
  parameter int NUM_DIG     = 2,
  parameter int ALARM_TICKS = 10,
  parameter int VAL_W       = $clog2(10**NUM_DIG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_valid_i,
  input  logic [3:0]       key_code_i,
  input  logic             tick_i,
  input  logic             blink_i,
  input  logic             tone_wave_i,
  output logic             led_o,
  output logic             tone_o,
  output logic             timing_o,
  output logic             alarm_o,
  output logic [VAL_W-1:0] secs_o
);
  logic             digit_hit, start_hit, clear_hit;
  logic [VAL_W-1:0] value;
  logic [VAL_W-1:0] count;
  kt_state_e        state;

  assign digit_hit = key_valid_i && is_digit(key_code_i);
  assign start_hit = key_valid_i && (key_code_i == KEY_START);
  assign clear_hit = key_valid_i && (key_code_i == KEY_CLEAR);

  kt_entry #(.NUM_DIG(NUM_DIG), .VAL_W(VAL_W)) u_entry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .digit_i (digit_hit),
    .code_i  (key_code_i),
    .clear_i (clear_hit),
    .value_o (value)
  );

  kt_ctrl #(.VAL_W(VAL_W), .ALARM_TICKS(ALARM_TICKS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_hit),
    .clear_i (clear_hit),
    .tick_i  (tick_i),
    .value_i (value),
    .state_o (state),
    .count_o (count)
  );

  kt_outmux #(.VAL_W(VAL_W)) u_out (
    .state_i     (state),
    .count_i     (count),
    .value_i     (value),
    .blink_i     (blink_i),
    .tone_wave_i (tone_wave_i),
    .led_o       (led_o),
    .tone_o      (tone_o),
    .timing_o    (timing_o),
    .alarm_o     (alarm_o),
    .secs_o      (secs_o)
  );
endmodule

// File: rtl/kt_checker.sv
module kt_checker #(
  parameter int VAL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             key_valid_i,
  input logic [3:0]       key_code_i,
  input logic             tick_i,
  input logic             blink_i,
  input logic             tone_wave_i,
  input logic             led_o,
  input logic             tone_o,
  input logic             timing_o,
  input logic             alarm_o,
  input logic [VAL_W-1:0] secs_o
);
  logic clr, strt;
  assign clr  = key_valid_i && key_code_i == 4'hC;
  assign strt = key_valid_i && key_code_i == 4'hF;

  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({timing_o, alarm_o})); // R8

  AST_RUN_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timing_o && tick_i && !clr && secs_o > VAL_W'(1))
    |=> (timing_o && secs_o == VAL_W'($past(secs_o) - 1'b1))); // R8

  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timing_o) |-> $past(strt)); // R5

  AST_ZERO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strt && !timing_o && secs_o == '0) |=> !timing_o); // R6

  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!timing_o && !alarm_o && secs_o == '0)); // R12

  AST_TONE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_o |-> !tone_o); // R11

  AST_LED_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> !led_o); // R10

  AST_BUSY_BLINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_o |-> (led_o == blink_i)); // R10
endmodule

bind kpad_timer kt_checker #(.VAL_W(VAL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_valid_i (key_valid_i),
  .key_code_i  (key_code_i),
  .tick_i      (tick_i),
  .blink_i     (blink_i),
  .tone_wave_i (tone_wave_i),
  .led_o       (led_o),
  .tone_o      (tone_o),
  .timing_o    (timing_o),
  .alarm_o     (alarm_o),
  .secs_o      (secs_o)
);

// File: tb/tb_kpad_timer.sv
module tb_kpad_timer;
  localparam int VAL_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             key_valid = 1'b0;
  logic [3:0]       key_code = '0;
  logic             tick = 1'b0;
  logic             blink = 1'b0;
  logic             tone_wave = 1'b0;
  logic             led, tone, timing, alarm;
  logic [VAL_W-1:0] secs;

  always #10 clk = ~clk;

  kpad_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .key_valid_i(key_valid), .key_code_i(key_code),
    .tick_i(tick), .blink_i(blink), .tone_wave_i(tone_wave),
    .led_o(led), .tone_o(tone), .timing_o(timing), .alarm_o(alarm), .secs_o(secs)
  );

  typedef struct {
    string            req;
    logic [VAL_W-1:0] secs;
    logic             timing, alarm, led, tone;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_err = 0;
  bit   done = 0;

  // reference model
  int m_tens = 0, m_units = 0, m_cnt = 0, m_acnt = 0;
  bit m_run = 0, m_alm = 0;

  function automatic int m_val();
    return m_tens * 10 + m_units;
  endfunction

  task automatic model(input bit kv, input logic [3:0] code, input bit tk);
    if (kv && code == 4'hC) begin
      m_tens = 0; m_units = 0; m_run = 0; m_alm = 0;
    end else begin
      bit started = 0;
      if (kv && code <= 4'd9) begin m_tens = m_units; m_units = int'(code); end
      if (kv && code == 4'hF && !m_run && m_val() != 0) begin
        m_run = 1; m_alm = 0; m_cnt = m_val(); started = 1;
      end
      if (!started && tk) begin
        if (m_run) begin
          if (m_cnt == 1) begin m_run = 0; m_alm = 1; m_acnt = 10; end
          else m_cnt--;
        end else if (m_alm) begin
          if (m_acnt == 1) m_alm = 0;
          m_acnt--;
        end
      end
    end
  endtask

  function automatic exp_t expect_now(input string req);
    exp_t e;
    e.req    = req;
    e.timing = m_run;
    e.alarm  = m_alm;
    e.secs   = VAL_W'(m_run ? m_cnt : m_val());
    e.led    = m_run ? blink : !m_alm;
    e.tone   = m_alm & tone_wave;
    return e;
  endfunction

  // driver: one cycle of stimulus, then queue the expected outputs
  task automatic drive(input string req, input bit kv, input logic [3:0] code, input bit tk);
    @(posedge clk); #1;
    key_valid = kv; key_code = code; tick = tk;
    @(posedge clk); #1;
    key_valid = 1'b0; tick = 1'b0;
    model(kv, code, tk);
    q.push_back(expect_now(req));
  endtask

  task automatic key(input string req, input logic [3:0] code);
    drive(req, 1'b1, code, 1'b0);
  endtask

  task automatic tck(input string req);
    drive(req, 1'b0, 4'h0, 1'b1);
  endtask

  task automatic level(input string req, input bit b, input bit t);
    @(posedge clk); #1;
    blink = b; tone_wave = t;
    q.push_back(expect_now(req));
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (secs !== e.secs || timing !== e.timing || alarm !== e.alarm ||
          led !== e.led || tone !== e.tone) begin
        n_err++;
        $display("FAIL %s: got secs=%0d run=%b alm=%b led=%b tone=%b exp secs=%0d run=%b alm=%b led=%b tone=%b",
                 e.req, secs, timing, alarm, led, tone,
                 e.secs, e.timing, e.alarm, e.led, e.tone);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    q.push_back(expect_now("R1"));

    key("R2", 4'd4);
    key("R2", 4'd2);          // 42
    key("R2", 4'd7);          // 27
    key("R3", 4'hA);
    key("R3", 4'hE);
    key("R3", 4'hB);
    key("R3", 4'hD);
    key("R4", 4'd9);
    key("R4", 4'd9);          // 99
    key("R12", 4'hC);
    key("R6", 4'hF);          // zero entry

    key("R2", 4'd0);
    key("R2", 4'd3);
    level("R10", 1'b1, 1'b1); // idle: led on, tone off
    key("R5", 4'hF);          // run 3
    level("R10", 1'b0, 1'b1);
    level("R10", 1'b1, 1'b0);
    key("R7", 4'hF);
    tck("R8");
    key("R7", 4'hF);
    tck("R8");
    tck("R8");                // alarm
    level("R11", 1'b1, 1'b1);
    level("R11", 1'b1, 1'b0);
    level("R11", 1'b0, 1'b1);
    for (int i = 0; i < 9; i++) tck("R9");
    tck("R9");                // back to idle

    key("R2", 4'd5);          // 35
    key("R5", 4'hF);
    tck("R8");
    drive("R12", 1'b1, 4'hC, 1'b1);

    key("R2", 4'd1);
    key("R5", 4'hF);
    tck("R8");                // alarm
    tck("R9");
    key("R12", 4'hC);
    level("R11", 1'b1, 1'b1);

    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule